// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out one block-move instruction. The instruction loads or stores any subset of a bank of word registers, using a single base address. A one-cycle start pulse hands the block four things: a selection mask with one bit per register, a base address, a direction flag and a base-update flag. The block then walks the mask from the lowest index upward. For each selected register it issues one word access over a valid/ready handshake. Each access carries the memory address, the register index and the direction. The addresses begin at the base and rise by one word for each access.

When the last access has been accepted, the block raises a one-cycle completion pulse. If the base-update flag was set, the completion pulse comes with an updated base. That value is the base plus one word per selected register, and the register file outside can write it back into the base register. A base that is not word-aligned is refused: the block reports an alignment error and issues no access. A mask with no bits set finishes at once. The register file, the memory and any exception handling sit outside the block.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `busy_o`, `acc_valid_o`, `done_o`, `align_err_o` and `wb_valid_o` are all 0.
- R2: An accepted start with an aligned, non-empty mask produces exactly one access per set bit of the mask. `acc_reg_o` is the index of that bit, and the indices come in strictly ascending order.
- R3: The k-th access (counting from 0) has `acc_addr_o` equal to base + 4·k, modulo 2^32.
- R4: `acc_load_o` equals the direction flag captured at start for every access of the instruction (1 = load, 0 = store).
- R5: While `acc_valid_o` is 1 and `acc_ready_i` is 0, the next cycle still shows `acc_valid_o` = 1, with `acc_addr_o` and `acc_reg_o` unchanged.
- R6: `done_o` is 1 for exactly one cycle. That cycle directly follows the cycle in which the final access was accepted, and `acc_valid_o` is 0 in it.
- R7: In the `done_o` cycle, `wb_valid_o` equals the base-update flag captured at start. When it is 1, `wb_base_o` equals base + 4·(number of selected registers).
- R8: If base bits [1:0] are not 00 at start, the next cycle shows `done_o` = 1 and `align_err_o` = 1, with no access and `wb_valid_o` = 0. This applies even when the mask is empty.
- R9: An aligned start with an all-zero mask gives `done_o` in the next cycle, with no access. If the base-update flag is set, `wb_base_o` equals the unchanged base.
- R10: A start pulse, or a change on the mask, base, direction or update inputs, while `busy_o` = 1 has no effect on the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| mask_i | input | 16 | Register selection mask, bit i selects register i |
| base_i | input | 32 | Base byte address |
| load_i | input | 1 | Direction: 1 load, 0 store |
| wb_i | input | 1 | Base-update request |
| busy_o | output | 1 | Instruction in progress |
| acc_valid_o | output | 1 | Word access offered |
| acc_ready_i | input | 1 | Memory side accepts the offered access |
| acc_addr_o | output | 32 | Byte address of the access |
| acc_reg_o | output | 4 | Register index of the access |
| acc_load_o | output | 1 | Direction of the access |
| done_o | output | 1 | One-cycle completion pulse |
| align_err_o | output | 1 | Misaligned base, given with `done_o` |
| wb_valid_o | output | 1 | Updated base is valid, given with `done_o` |
| wb_base_o | output | 32 | Updated base value |

## Verification
The test drives several kinds of mask through the sequencer:
- The four-register sparse case at base 1000 shows that the walk skips gaps while the addresses stay consecutive.
- The full mask and single-bit masks at both ends of the index range expose off-by-one faults in the picker and the address step.
- Empty masks and misaligned bases, including a misaligned base with an empty mask, separate the two zero-access exits and their relative priority.
- Random masks and random ready stalls mix dense and sparse selections with hold periods. During these runs, stray starts and input changes while busy show that the captured instruction is left alone.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/blkxfer_pick.sv
// Finds the lowest set bit of the remaining mask, gives its index,
// and gives the mask with that bit cleared.
module blkxfer_pick #(
   parameter int NREG = 16,
   localparam int IW = $clog2(NREG)
) (
   input  logic [NREG-1:0] mask_i,
   output logic [IW-1:0]   idx_o,
   output logic [NREG-1:0] rest_o
);
   logic [NREG-1:0] first_oh;

   assign first_oh = mask_i & (~mask_i + NREG'(1));
   assign rest_o   = mask_i & ~first_oh;

   for (genvar b = 0; b < IW; b++) begin : g_bit
      logic [NREG-1:0] sel;
      for (genvar i = 0; i < NREG; i++) begin : g_i
         if (((i >> b) & 1) == 1) begin : g_on
            assign sel[i] = first_oh[i];
         end else begin : g_off
            assign sel[i] = 1'b0;
         end
      end
      assign idx_o[b] = |sel;
   end
endmodule

// File: rtl/blkxfer_addr.sv
// Address register: loaded with the base at start, stepped one word per accepted access.
module blkxfer_addr #(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          step_en_i,
   output logic [AW-1:0] addr_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o <= '0;
      end else if (load_en_i) begin
         addr_o <= load_val_i;
      end else if (step_en_i) begin
         addr_o <= addr_o + AW'(STEP);
      end
   end
endmodule

// File: rtl/blkxfer_ctrl.sv
// Sequencing state machine: idle, transfer, finish.
module blkxfer_ctrl
   import blkxfer_pkg::*;
#(
   parameter int NREG = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            aligned_i,
   input  logic [NREG-1:0] mask_i,
   input  logic            load_i,
   input  logic            wb_i,
   input  logic            acc_ready_i,
   input  logic [NREG-1:0] rest_i,
   output logic [NREG-1:0] mask_q_o,
   output logic            busy_o,
   output logic            acc_valid_o,
   output logic            acc_load_o,
   output logic            done_o,
   output logic            align_err_o,
   output logic            wb_valid_o,
   output logic            addr_load_o,
   output logic            addr_step_o
);
   seq_state_e state_q;
   logic       wb_q;
   logic       err_q;
   logic       take;

   assign take = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mask_q_o   <= '0;
         acc_load_o <= 1'b0;
         wb_q       <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mask_q_o   <= mask_i;
                  acc_load_o <= load_i;
                  wb_q       <= wb_i;
                  err_q      <= !aligned_i;
                  state_q    <= (!aligned_i || mask_i == '0) ? ST_FIN : ST_XFER;
               end
            end
            ST_XFER: begin
               if (acc_ready_i) begin
                  mask_q_o <= rest_i;
                  if (rest_i == '0) state_q <= ST_FIN;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign acc_valid_o = (state_q == ST_XFER);
   assign done_o      = (state_q == ST_FIN);
   assign align_err_o = done_o && err_q;
   assign wb_valid_o  = done_o && wb_q && !err_q;
   assign addr_load_o = take;
   assign addr_step_o = acc_valid_o && acc_ready_i;
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
   parameter int NREG       = 16,
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4,
   localparam int IW         = $clog2(NREG),
   localparam int ALIGN_BITS = $clog2(WORD_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [NREG-1:0] mask_i,
   input  logic [AW-1:0]   base_i,
   input  logic            load_i,
   input  logic            wb_i,
   output logic            busy_o,
   output logic            acc_valid_o,
   input  logic            acc_ready_i,
   output logic [AW-1:0]   acc_addr_o,
   output logic [IW-1:0]   acc_reg_o,
   output logic            acc_load_o,
   output logic            done_o,
   output logic            align_err_o,
   output logic            wb_valid_o,
   output logic [AW-1:0]   wb_base_o
);
   // Elaboration-time parameter checks
   if (NREG < 2) begin : g_bad_nreg
      $error("blkxfer_seq: NREG must be at least 2");
   end
   if ((1 << ALIGN_BITS) != WORD_BYTES) begin : g_bad_word
      $error("blkxfer_seq: WORD_BYTES must be a power of two");
   end
   if (AW <= ALIGN_BITS) begin : g_bad_aw
      $error("blkxfer_seq: AW too narrow for word alignment");
   end

   logic            aligned;
   logic [NREG-1:0] mask_q;
   logic [NREG-1:0] rest;
   logic            addr_load;
   logic            addr_step;
   logic [AW-1:0]   addr_q;

   // Alignment test: byte-wide words need none
   if (ALIGN_BITS > 0) begin : g_align_chk
      assign aligned = ~|base_i[ALIGN_BITS-1:0];
   end else begin : g_align_none
      assign aligned = 1'b1;
   end

   blkxfer_pick #(.NREG(NREG)) u_pick (
      .mask_i (mask_q),
      .idx_o  (acc_reg_o),
      .rest_o (rest)
   );

   blkxfer_ctrl #(.NREG(NREG)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .aligned_i   (aligned),
      .mask_i      (mask_i),
      .load_i      (load_i),
      .wb_i        (wb_i),
      .acc_ready_i (acc_ready_i),
      .rest_i      (rest),
      .mask_q_o    (mask_q),
      .busy_o      (busy_o),
      .acc_valid_o (acc_valid_o),
      .acc_load_o  (acc_load_o),
      .done_o      (done_o),
      .align_err_o (align_err_o),
      .wb_valid_o  (wb_valid_o),
      .addr_load_o (addr_load),
      .addr_step_o (addr_step)
   );

   blkxfer_addr #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en_i  (addr_load),
      .load_val_i (base_i),
      .step_en_i  (addr_step),
      .addr_o     (addr_q)
   );

   assign acc_addr_o = addr_q;
   assign wb_base_o  = addr_q;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
   parameter int NREG       = 16,
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4,
   localparam int IW = $clog2(NREG),
   localparam int CW = $clog2(NREG + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [NREG-1:0] mask_i,
   input logic [AW-1:0]   base_i,
   input logic            load_i,
   input logic            wb_i,
   input logic            busy_o,
   input logic            acc_valid_o,
   input logic            acc_ready_i,
   input logic [AW-1:0]   acc_addr_o,
   input logic [IW-1:0]   acc_reg_o,
   input logic            acc_load_o,
   input logic            done_o,
   input logic            align_err_o,
   input logic            wb_valid_o,
   input logic [AW-1:0]   wb_base_o
);
   logic [AW-1:0]   base_l;
   logic [NREG-1:0] mask_l;
   logic            load_l;
   logic            wb_l;
   logic [CW-1:0]   cnt;
   logic            take;
   logic            misal;

   assign take  = start_i && !busy_o;
   assign misal = (base_i & AW'(WORD_BYTES - 1)) != '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_l <= '0;
         mask_l <= '0;
         load_l <= 1'b0;
         wb_l   <= 1'b0;
         cnt    <= '0;
      end else if (take) begin
         base_l <= base_i;
         mask_l <= mask_i;
         load_l <= load_i;
         wb_l   <= wb_i;
         cnt    <= '0;
      end else if (acc_valid_o && acc_ready_i) begin
         cnt <= cnt + CW'(1);
      end
   end

   p_sel_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_o |-> mask_l[acc_reg_o]);

   p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid_o && acc_ready_i) && acc_valid_o |-> acc_reg_o > $past(acc_reg_o));

   p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take) && acc_valid_o |-> acc_addr_o == base_l);

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid_o && acc_ready_i) && acc_valid_o
         |-> acc_addr_o == $past(acc_addr_o) + AW'(WORD_BYTES));

   p_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_o |-> acc_load_o == load_l);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_o && !acc_ready_i
         |=> acc_valid_o && $stable(acc_addr_o) && $stable(acc_reg_o));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid_o && acc_ready_i) && !acc_valid_o |-> done_o);

   p_wb_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> done_o && wb_l
         && wb_base_o == base_l + (AW'(cnt) * AW'(WORD_BYTES)));

   p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take && misal |=> done_o && align_err_o && !acc_valid_o && !wb_valid_o);

   p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take && mask_i == '0 |=> done_o && !acc_valid_o);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(
   .NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
   .base_i(base_i), .load_i(load_i), .wb_i(wb_i), .busy_o(busy_o),
   .acc_valid_o(acc_valid_o), .acc_ready_i(acc_ready_i),
   .acc_addr_o(acc_addr_o), .acc_reg_o(acc_reg_o), .acc_load_o(acc_load_o),
   .done_o(done_o), .align_err_o(align_err_o), .wb_valid_o(wb_valid_o),
   .wb_base_o(wb_base_o)
);

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [15:0] mask_i;
   logic [31:0] base_i;
   logic        load_i;
   logic        wb_i;
   logic        busy_o;
   logic        acc_valid_o;
   logic        acc_ready_i;
   logic [31:0] acc_addr_o;
   logic [3:0]  acc_reg_o;
   logic        acc_load_o;
   logic        done_o;
   logic        align_err_o;
   logic        wb_valid_o;
   logic [31:0] wb_base_o;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   blkxfer_seq u_blkxfer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
      .base_i(base_i), .load_i(load_i), .wb_i(wb_i), .busy_o(busy_o),
      .acc_valid_o(acc_valid_o), .acc_ready_i(acc_ready_i),
      .acc_addr_o(acc_addr_o), .acc_reg_o(acc_reg_o), .acc_load_o(acc_load_o),
      .done_o(done_o), .align_err_o(align_err_o), .wb_valid_o(wb_valid_o),
      .wb_base_o(wb_base_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int pop16(input logic [15:0] m);
      int c = 0;
      for (int i = 0; i < 16; i++) if (m[i]) c++;
      return c;
   endfunction

   // index of the k-th set bit, ascending
   function automatic int nth_reg(input logic [15:0] m, input int k);
      int c = 0;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            if (c == k) return i;
            c++;
         end
      end
      return -1;
   endfunction

   task automatic run_cmd(input logic [15:0] m, input logic [31:0] b, input bit ld,
                          input bit wbf, input int rdy_pct, input bit poke);
      int n = pop16(m);
      bit mis = (b[1:0] != 2'b00);
      int k = 0;
      bit prev_hold = 0;
      bit last_acc = 0;
      bit seen_done = 0;
      bit r;
      logic [31:0] prev_addr = '0;
      logic [3:0]  prev_reg = '0;
      @(negedge clk);
      start_i = 1'b1; mask_i = m; base_i = b; load_i = ld; wb_i = wbf; acc_ready_i = 1'b0;
      @(negedge clk);
      // R10: scramble the command inputs while busy
      start_i = 1'b0; mask_i = 16'($urandom); base_i = $urandom; load_i = ~ld; wb_i = ~wbf;
      chk(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 32'd1);
      for (int it = 0; it < 400 && !seen_done; it++) begin
         if (done_o) begin
            seen_done = 1;
            chk(acc_valid_o == 1'b0, "R6", "valid during done", 32'(acc_valid_o), 32'd0);
            if (mis) begin
               chk(align_err_o == 1'b1, "R8", "align error", 32'(align_err_o), 32'd1);
               chk(k == 0, "R8", "accesses on misaligned base", 32'(k), 32'd0);
               chk(it == 0, "R8", "done latency", 32'(it), 32'd0);
               chk(wb_valid_o == 1'b0, "R8", "writeback on error", 32'(wb_valid_o), 32'd0);
            end else begin
               chk(align_err_o == 1'b0, "R8", "spurious align error", 32'(align_err_o), 32'd0);
               chk(k == n, "R2", "access count", 32'(k), 32'(n));
               if (n == 0) chk(it == 0, "R9", "empty done latency", 32'(it), 32'd0);
               else chk(last_acc, "R6", "done not right after last accept", 32'(last_acc), 32'd1);
               chk(wb_valid_o == wbf, "R7", "writeback valid", 32'(wb_valid_o), 32'(wbf));
               if (wbf) chk(wb_base_o == b + 32'(4 * n), (n == 0) ? "R9" : "R7",
                            "writeback base", wb_base_o, b + 32'(4 * n));
            end
         end else begin
            chk(acc_valid_o == 1'b1 && !mis && k < n, "R2", "unexpected idle or access",
                32'(acc_valid_o), 32'd1);
            if (acc_valid_o) begin
               chk(32'(acc_reg_o) == 32'(nth_reg(m, k)), "R2", "register index",
                   32'(acc_reg_o), 32'(nth_reg(m, k)));
               chk(acc_addr_o == b + 32'(4 * k), "R3", "address", acc_addr_o, b + 32'(4 * k));
               chk(acc_load_o == ld, "R4", "direction", 32'(acc_load_o), 32'(ld));
               if (prev_hold) begin
                  chk(acc_addr_o == prev_addr, "R5", "held address", acc_addr_o, prev_addr);
                  chk(acc_reg_o == prev_reg, "R5", "held register", 32'(acc_reg_o), 32'(prev_reg));
               end
               r = (($urandom % 100) < rdy_pct);
               if (poke && it == 0) begin
                  r = 1'b0;
                  start_i = 1'b1;   // R10: stray start while busy
               end
               acc_ready_i = r;
               prev_hold = !r;
               prev_addr = acc_addr_o;
               prev_reg = acc_reg_o;
               last_acc = r && (k + 1 == n);
               if (r) k++;
            end
         end
         @(negedge clk);
         start_i = 1'b0;
         acc_ready_i = 1'b0;
      end
      if (!seen_done) chk(1'b0, "R6", "no done seen", 32'd0, 32'd1);
      chk(done_o == 1'b0, "R6", "done longer than one cycle", 32'(done_o), 32'd0);
      chk(busy_o == 1'b0, "R6", "busy after done", 32'(busy_o), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] m;
      logic [31:0] b;
      void'($urandom(32'h1d2c3b4a));
      rst_n = 1'b0; start_i = 1'b0; mask_i = '0; base_i = '0;
      load_i = 1'b0; wb_i = 1'b0; acc_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o == 0, "R1", "busy", 32'(busy_o), 0);
      chk(acc_valid_o == 0, "R1", "valid", 32'(acc_valid_o), 0);
      chk(done_o == 0, "R1", "done", 32'(done_o), 0);
      chk(align_err_o == 0, "R1", "align error", 32'(align_err_o), 0);
      chk(wb_valid_o == 0, "R1", "writeback valid", 32'(wb_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(acc_valid_o == 0 && done_o == 0, "R1", "idle after release",
          32'({acc_valid_o, done_o}), 0);

      // directed corners
      run_cmd(16'h00C3, 32'd1000, 1'b1, 1'b1, 100, 1'b0);   // four regs at 1000 -> 1016
      run_cmd(16'hFFFF, 32'h0000_2000, 1'b0, 1'b1, 60, 1'b1);
      run_cmd(16'h8000, 32'h0000_0040, 1'b1, 1'b1, 40, 1'b0);
      run_cmd(16'h0001, 32'hFFFF_FFFC, 1'b0, 1'b1, 100, 1'b0);
      run_cmd(16'h0000, 32'h0000_1234 & 32'hFFFF_FFFC, 1'b1, 1'b1, 100, 1'b0);  // R9
      run_cmd(16'h0000, 32'h0000_0100, 1'b0, 1'b0, 100, 1'b0);
      run_cmd(16'h00C3, 32'd1002, 1'b1, 1'b1, 100, 1'b0);   // R8
      run_cmd(16'h0000, 32'h0000_0101, 1'b0, 1'b1, 100, 1'b0);  // R8 beats R9
      run_cmd(16'h8001, 32'h0000_0500, 1'b1, 1'b0, 30, 1'b1);

      // constrained random
      for (int i = 0; i < 50; i++) begin
         m = 16'($urandom);
         if (i % 3 == 0) m = m & 16'($urandom) & 16'($urandom);
         b = $urandom;
         if ($urandom % 8 != 0) b[1:0] = 2'b00;
         run_cmd(m, b, 1'($urandom), 1'($urandom), 30 + int'($urandom % 71), 1'($urandom));
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule